// File: doc/BRIEF.md
# Interleaved Multi-Bank Register File with Read Conflict Serialisation

This block is a 256-entry register file for a processor with four functional units that each want an operand in the same cycle. It does not use a costly four-port array. Storage is split into eight banks, and each bank has a single read port and a single write port. Register numbers are interleaved across the banks. A run of consecutive registers therefore falls into different banks, and all of them can be read together.

A batch of up to four read requests is accepted while the block is idle. Each cycle after acceptance, every bank serves one register. Every pending unit that asked for that register receives the same bank output, so one read is broadcast to several units. Units that want different registers in the same bank are served in later cycles, lowest unit index first. Each unit sees a one-cycle valid pulse when its data arrives. A done pulse marks the cycle in which the last read of the batch completes. A separate write port updates one register per cycle, in parallel with the reads.

Top module: `bankRegFile`

## Requirements
- R1: Register number r lives in bank r[2:0] at word r[7:3]. A write with wrEn high stores wrData at wrAddr on the clock edge, and a later read of that register returns it.
- R2: A batch is accepted on an edge where ready is high and reqEn is nonzero. Units whose requests fall in pairwise distinct banks all receive rdValid and data on the first edge after the accepting edge.
- R3: Units that request the same register in one batch all receive that register's value on the same edge.
- R4: Within a bank, distinct registers are served one per edge. The order follows the lowest unit index that requests each register. A unit whose register is the k-th distinct register of its bank (k from 0) gets its data on edge k+1 after acceptance.
- R5: Each enabled unit gets exactly one rdValid pulse per batch, with its data in its 32-bit slice of rdData (unit u at bits 32u+31..32u).
- R6: ready is high exactly when no read of the current batch is outstanding. Requests presented while ready is low are ignored.
- R7: batchDone pulses for one cycle, on the same edge as the last rdValid of the batch.
- R8: When a register is written on the same edge that it is read, the reader receives the old value. Later reads return the new value.
- R9: After reset, ready is high and rdValid and batchDone are low.
- R10: A unit whose reqEn bit is low at acceptance gets no rdValid pulse in that batch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqEn | input | 4 | Per-unit read request enable |
| reqAddr | input | 32 | Per-unit register number, 8 bits per unit |
| ready | output | 1 | Block idle, a new batch can be accepted |
| wrEn | input | 1 | Write enable |
| wrAddr | input | 8 | Register number to write |
| wrData | input | 32 | Write data |
| rdValid | output | 4 | Per-unit read data valid pulse |
| rdData | output | 128 | Per-unit read data, 32 bits per unit |
| batchDone | output | 1 | Pulse on the edge that completes a batch |

## Verification
Three things can fall on the same edge: a bank read for a pending unit, a write to that same register through the write port, and the broadcast of a read to several units. The bench drives the write in the same cycle as the first serving edge of a batch that also broadcasts. It expects the old value on every receiving unit, and it expects the new value in the next batch. It also overlaps a serialised four-round conflict with new requests presented while the block is busy. The result is judged by the order and cycle of every data pulse, and by the absence of any extra pulse.

// File: rtl/rfPkg.sv
package rfPkg;
  localparam int RF_UNITS  = 4;
  localparam int RF_BANKS  = 8;
  localparam int RF_DEPTH  = 32;
  localparam int RF_DATA_W = 32;
  localparam int RF_BANK_W = $clog2(RF_BANKS);
  localparam int RF_WORD_W = $clog2(RF_DEPTH);
  localparam int RF_REG_W  = RF_BANK_W + RF_WORD_W;

  typedef logic [RF_REG_W-1:0]  regIdx_t;
  typedef logic [RF_BANK_W-1:0] bankIdx_t;
  typedef logic [RF_WORD_W-1:0] wordIdx_t;
  typedef logic [RF_DATA_W-1:0] word_t;
  typedef logic [RF_UNITS-1:0]  unitMask_t;

  typedef struct packed {
    logic      acceptBatch;
    unitMask_t serveMask;
  } rfStrobe_t;

  function automatic bankIdx_t bankOf(regIdx_t r);
    return r[RF_BANK_W-1:0];
  endfunction

  function automatic wordIdx_t wordOf(regIdx_t r);
    return r[RF_REG_W-1:RF_BANK_W];
  endfunction
endpackage

// File: rtl/rfControl.sv
module rfControl
  import rfPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  unitMask_t  reqEn,
  input  regIdx_t    heldAddr [RF_UNITS],
  output rfStrobe_t  strobe,
  output logic       ready,
  output logic       batchDone
);
  unitMask_t pending;
  unitMask_t serve;

  assign ready = (pending == '0);

  always_comb begin
    for (int u = 0; u < RF_UNITS; u++) begin
      int lead;
      lead = u;
      for (int j = RF_UNITS - 1; j >= 0; j--) begin
        if (pending[j] && bankOf(heldAddr[j]) == bankOf(heldAddr[u])) lead = j;
      end
      serve[u] = pending[u] && (heldAddr[u] == heldAddr[lead]);
    end
  end

  always_comb begin
    strobe.acceptBatch = ready && (reqEn != '0);
    strobe.serveMask   = serve;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending   <= '0;
      batchDone <= 1'b0;
    end else begin
      pending   <= strobe.acceptBatch ? reqEn : (pending & ~serve);
      batchDone <= (pending != '0) && ((pending & ~serve) == '0);
    end
  end

  // R4: every busy cycle retires at least one pending unit
  a_r4_progress: assert property (@(posedge clk) disable iff (!rstN)
    (pending != '0) |=> (($countones(pending) < $countones($past(pending))) || $past(strobe.acceptBatch)));
  // R4: something is served whenever work is outstanding
  a_r4_serve_when_busy: assert property (@(posedge clk) disable iff (!rstN)
    (pending != '0) |-> (serve != '0));
  // R7: done leaves the block idle
  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    batchDone |-> ready);
endmodule

// File: rtl/rfDatapath.sv
module rfDatapath
  import rfPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  rfStrobe_t  strobe,
  input  regIdx_t    reqAddr  [RF_UNITS],
  input  logic       wrEn,
  input  regIdx_t    wrAddr,
  input  word_t      wrData,
  output regIdx_t    heldAddr [RF_UNITS],
  output word_t      rdData   [RF_UNITS],
  output unitMask_t  rdValid
);
  word_t bankOut [RF_BANKS];

  for (genvar b = 0; b < RF_BANKS; b++) begin : gBank
    word_t    bankMem [RF_DEPTH];
    wordIdx_t portWord;

    always_comb begin
      portWord = '0;
      for (int u = 0; u < RF_UNITS; u++) begin
        if (strobe.serveMask[u] && bankOf(heldAddr[u]) == bankIdx_t'(b))
          portWord = wordOf(heldAddr[u]);
      end
    end

    assign bankOut[b] = bankMem[portWord];

    always_ff @(posedge clk) begin
      if (wrEn && bankOf(wrAddr) == bankIdx_t'(b))
        bankMem[wordOf(wrAddr)] <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int u = 0; u < RF_UNITS; u++) begin
        heldAddr[u] <= '0;
        rdData[u]   <= '0;
      end
      rdValid <= '0;
    end else begin
      for (int u = 0; u < RF_UNITS; u++) begin
        if (strobe.acceptBatch) heldAddr[u] <= reqAddr[u];
        if (strobe.serveMask[u]) rdData[u] <= bankOut[bankOf(heldAddr[u])];
      end
      rdValid <= strobe.serveMask;
    end
  end

  // R4: a bank port serves a single word per edge
  for (genvar i = 0; i < RF_UNITS; i++) begin : gPairI
    for (genvar j = i + 1; j < RF_UNITS; j++) begin : gPairJ
      a_r4_one_word_per_bank: assert property (@(posedge clk) disable iff (!rstN)
        (strobe.serveMask[i] && strobe.serveMask[j] &&
         bankOf(heldAddr[i]) == bankOf(heldAddr[j])) |-> (heldAddr[i] == heldAddr[j]));
    end
  end
endmodule

// File: rtl/bankRegFile.sv
module bankRegFile
  import rfPkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [RF_UNITS-1:0]           reqEn,
  input  logic [RF_UNITS*RF_REG_W-1:0]  reqAddr,
  output logic                          ready,
  input  logic                          wrEn,
  input  logic [RF_REG_W-1:0]           wrAddr,
  input  logic [RF_DATA_W-1:0]          wrData,
  output logic [RF_UNITS-1:0]           rdValid,
  output logic [RF_UNITS*RF_DATA_W-1:0] rdData,
  output logic                          batchDone
);
  rfStrobe_t strobe;
  regIdx_t   reqAddrArr [RF_UNITS];
  regIdx_t   heldAddr   [RF_UNITS];
  word_t     rdDataArr  [RF_UNITS];

  for (genvar u = 0; u < RF_UNITS; u++) begin : gUnpack
    assign reqAddrArr[u] = reqAddr[u*RF_REG_W +: RF_REG_W];
    assign rdData[u*RF_DATA_W +: RF_DATA_W] = rdDataArr[u];
  end

  rfControl u_ctrl (
    .clk(clk), .rstN(rstN), .reqEn(reqEn), .heldAddr(heldAddr),
    .strobe(strobe), .ready(ready), .batchDone(batchDone)
  );

  rfDatapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddrArr),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .heldAddr(heldAddr), .rdData(rdDataArr), .rdValid(rdValid)
  );

  // R6: two idle edges in a row produce no read data
  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    ($past(ready) && $past(ready, 2)) |-> (rdValid == '0));
  // R7: done only coincides with data delivery
  a_r7_done_with_data: assert property (@(posedge clk) disable iff (!rstN)
    batchDone |-> (rdValid != '0));
endmodule

// File: tb/bankRegFile_tb.sv
module bankRegFile_tb;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [3:0]   reqEn = '0;
  logic [31:0]  reqAddr = '0;
  logic         ready;
  logic         wrEn = 1'b0;
  logic [7:0]   wrAddr = '0;
  logic [31:0]  wrData = '0;
  logic [3:0]   rdValid;
  logic [127:0] rdData;
  logic         batchDone;

  bankRegFile u_dut (
    .clk(clk), .rstN(rstN), .reqEn(reqEn), .reqAddr(reqAddr), .ready(ready),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdValid(rdValid), .rdData(rdData), .batchDone(batchDone)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int expDone = -1;
  string doneTag = "R7";
  bit finished = 0;
  logic [31:0] refMem [256];

  int qUnit [$];
  int qCyc [$];
  logic [31:0] qData [$];
  string qTag [$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // monitor: pops expected items as valids appear
  always @(negedge clk) begin
    if (rstN) begin
      for (int u = 0; u < 4; u++) begin
        if (rdValid[u]) begin
          if (qUnit.size() == 0) begin
            check(0, "R6", "unexpected rdValid unit", u, 0);
          end else begin
            int eu; int ec; logic [31:0] ed; string et;
            eu = qUnit.pop_front(); ec = qCyc.pop_front();
            ed = qData.pop_front(); et = qTag.pop_front();
            check(eu == u, et, "unit order", u, eu);
            check(ec == cyc, et, "arrival cycle", cyc, ec);
            check(rdData[u*32 +: 32] == ed, et, "data", rdData[u*32 +: 32], ed);
          end
        end
      end
      if (batchDone || cyc == expDone)
        check(batchDone && cyc == expDone, doneTag, "batchDone cycle", cyc, expDone);
    end
  end

  task automatic writeReg(logic [7:0] r, logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = r; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    refMem[r] = d;
  endtask

  // driver: computes rounds from R4, pushes expectations, drives a batch
  task automatic runBatch(logic [3:0] en, logic [7:0] a0, logic [7:0] a1,
                          logic [7:0] a2, logic [7:0] a3, string tag,
                          bit poke, bit doWrite, logic [7:0] wReg, logic [31:0] wVal);
    logic [7:0] a [4];
    int round [4];
    int maxRound;
    int acc;
    a[0] = a0; a[1] = a1; a[2] = a2; a[3] = a3;
    maxRound = 0;
    for (int u = 0; u < 4; u++) begin
      round[u] = 0;
      if (en[u]) begin
        int distinct;
        distinct = 0;
        for (int j = 0; j < u; j++) begin
          if (en[j] && a[j][2:0] == a[u][2:0] && a[j] != a[u]) begin
            bit seen;
            seen = 0;
            for (int k = 0; k < j; k++)
              if (en[k] && a[k] == a[j]) seen = 1;
            if (!seen) distinct++;
          end
        end
        for (int j = 0; j < u; j++)
          if (en[j] && a[j] == a[u]) distinct = round[j];
        round[u] = distinct;
        if (distinct > maxRound) maxRound = distinct;
      end
    end
    @(negedge clk);
    check(ready == 1'b1, "R6", "ready before batch", ready, 1);
    acc = cyc + 1;
    for (int r = 0; r < 4; r++)
      for (int u = 0; u < 4; u++)
        if (en[u] && round[u] == r) begin
          qUnit.push_back(u); qCyc.push_back(acc + 1 + r);
          qData.push_back(refMem[a[u]]); qTag.push_back(tag);
        end
    expDone = acc + 1 + maxRound;
    doneTag = {"R7/", tag};
    reqEn = en;
    reqAddr = {a3, a2, a1, a0};
    @(negedge clk);
    if (poke) begin
      reqEn = 4'b1111;
      reqAddr = {8'd100, 8'd101, 8'd102, 8'd103};
      check(ready == 1'b0, "R6", "ready while busy", ready, 0);
      @(negedge clk);
      @(negedge clk);
      reqEn = '0;
    end else begin
      reqEn = '0;
      if (doWrite) begin
        wrEn = 1'b1; wrAddr = wReg; wrData = wVal;
        @(negedge clk);
        wrEn = 1'b0;
        refMem[wReg] = wVal;
      end
    end
    while (qUnit.size() != 0 || cyc <= expDone) @(negedge clk);
    check(ready == 1'b1, "R6", "ready after batch", ready, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(0, "WATCHDOG", "timeout", cyc, 0);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(ready == 1'b1, "R9", "ready at reset", ready, 1);
    check(rdValid == 4'b0, "R9", "rdValid at reset", rdValid, 0);
    check(batchDone == 1'b0, "R9", "batchDone at reset", batchDone, 0);
    rstN = 1'b1;
    for (int r = 0; r < 256; r++)
      writeReg(8'(r), 32'hC0DE_0000 ^ (32'(r) * 32'h0101_0107));
    // R1/R2: consecutive run lands in distinct banks
    runBatch(4'b1111, 8'd40, 8'd41, 8'd42, 8'd43, "R1", 0, 0, 0, 0);
    runBatch(4'b1111, 8'd8, 8'd17, 8'd26, 8'd35, "R2", 0, 0, 0, 0);
    // R3: full broadcast
    runBatch(4'b1111, 8'd77, 8'd77, 8'd77, 8'd77, "R3", 0, 0, 0, 0);
    // R4: four registers in bank 3
    runBatch(4'b1111, 8'd3, 8'd11, 8'd19, 8'd27, "R4", 0, 0, 0, 0);
    // R4: reversed priority pattern with a repeat
    runBatch(4'b1111, 8'd29, 8'd5, 8'd29, 8'd13, "R4", 0, 0, 0, 0);
    // R3/R4 mixed broadcast and conflict
    runBatch(4'b1111, 8'd5, 8'd13, 8'd5, 8'd6, "R3", 0, 0, 0, 0);
    // R10/R5: partial enable
    runBatch(4'b0101, 8'd9, 8'd9, 8'd18, 8'd18, "R10", 0, 0, 0, 0);
    runBatch(4'b1000, 8'd1, 8'd2, 8'd3, 8'd255, "R5", 0, 0, 0, 0);
    // R6: requests while busy are ignored
    runBatch(4'b1111, 8'd2, 8'd10, 8'd18, 8'd26, "R6", 1, 0, 0, 0);
    // R8: write on the serving edge, broadcast read gets old value
    runBatch(4'b0111, 8'd60, 8'd60, 8'd61, 8'd0, "R8", 0, 1, 8'd60, 32'hFEED_BEEF);
    runBatch(4'b0011, 8'd60, 8'd60, 8'd0, 8'd0, "R8", 0, 0, 0, 0);
    // R1: write then read back through a conflicting batch
    writeReg(8'd250, 32'h1234_5678);
    runBatch(4'b1001, 8'd250, 8'd0, 8'd0, 8'd242, "R1", 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    check(qUnit.size() == 0, "R5", "leftover expectations", qUnit.size(), 0);
    summary();
  end
endmodule